// File: doc/BRIEF.md
# Dual-Rate CAN Bit Timing Generator

This block divides the controller clock into time quanta and groups the quanta into bits. For each bit it marks the point where the bus is sampled and the last clock of the bit. It holds two separate timing sets, each with its own prescaler and two segment lengths. The slow set governs arbitration. The fast set governs the data phase of a flexible-data-rate frame.

The protocol layer tells the block three things: that the rate-switch bit was sampled recessive, that the CRC delimiter has been reached, and that an error was detected. The block uses these to choose the timing set for the next bit. It enters the fast set only after a recessive rate-switch bit. It returns to the slow set on a CRC-delimiter request or an error request, whichever arrives first. A set change only ever takes effect at a bit boundary.

Both sets are captured when the frame starts, so the configuration inputs may change freely while a frame is in progress. Edge resynchronisation, hard-sync detection and frame parsing belong to other blocks.

Top module: `dual_rate_bit_timer`

## Requirements
- R1: After reset, `fast_phase` is 0 and, until the first `frame_start`, the block runs the minimum configuration: one clock per quantum and four quanta per bit.
- R2: A quantum lasts P clocks, where P is the prescaler of the active set. A prescaler value of 0 acts as 1. `tq_strobe` is high on the last clock of every quantum.
- R3: A bit lasts 1 + S1 + S2 quanta. `sample_pt` is high on the last clock of quantum index S1, counting the sync quantum as index 0. `bit_end` is high on the last clock of the bit.
- R4: S1 values below 2 act as 2 and S2 values of 0 act as 1, so no bit is shorter than 4 quanta. `sample_pt` and `bit_end` are never high in the same clock.
- R5: A `frame_start` pulse captures both timing sets and selects the slow set. The first clock after it is clock 0 of quantum 0 of a new bit. Changes on the configuration inputs after that capture have no effect on `tq_strobe`, `sample_pt` or `bit_end` until the next `frame_start`.
- R6: A `brs_recessive` pulse in any clock of a slow-set bit, including the clock where `bit_end` is high, makes the next bit use the fast set (`fast_phase` = 1). If no such pulse occurs, every bit of the frame uses the slow set.
- R7: A `crc_delim` pulse in any clock of a fast-set bit makes the next bit use the slow set.
- R8: An `err_det` pulse in any clock of a bit makes the next bit use the slow set. When it arrives in the same bit as `brs_recessive`, it cancels the pending switch to the fast set.
- R9: `fast_phase` and the active timing set change only on the clock after `bit_end` or `frame_start`, never inside a bit. A `brs_recessive` pulse during a fast-set bit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Start of frame: capture both sets and restart the bit |
| slow_presc | input | PRESC_W | Arbitration-phase prescaler, in clocks per quantum |
| slow_seg1 | input | SEG1_W | Arbitration-phase segment before the sample point, in quanta |
| slow_seg2 | input | SEG2_W | Arbitration-phase segment after the sample point, in quanta |
| fast_presc | input | PRESC_W | Data-phase prescaler, in clocks per quantum |
| fast_seg1 | input | SEG1_W | Data-phase segment before the sample point, in quanta |
| fast_seg2 | input | SEG2_W | Data-phase segment after the sample point, in quanta |
| brs_recessive | input | 1 | The rate-switch bit was sampled recessive |
| crc_delim | input | 1 | The CRC delimiter has been reached; return to the slow set |
| err_det | input | 1 | An error was detected; return to the slow set |
| tq_strobe | output | 1 | Last clock of a quantum |
| sample_pt | output | 1 | Sample point of the current bit |
| bit_end | output | 1 | Last clock of the current bit |
| fast_phase | output | 1 | The current bit uses the fast set |

## Verification
The hardest cases are requests that arrive in the last clock of a bit, because the request and the boundary fall in the same clock. Also hard are an error that lands in the same bit as the rate-switch indication, and a restart that cuts a fast bit short. The bench times each request to a chosen clock index inside a chosen bit. It then checks every clock of the following bits against quantum and bit lengths that it works out from the captured configuration.

Beyond those cases, the bench sweeps prescalers 1 to 3 and several pairs of segment lengths for both sets. Each sweep runs a complete slow, fast, slow sequence.

// File: rtl/dual_rate_pkg.sv
// Shared definitions for the dual-rate bit timer.
// Assumes: two timing sets, with index 0 = slow (arbitration) and 1 = fast (data).
package dual_rate_pkg;
    typedef enum logic {
        RATE_SLOW = 1'b0,
        RATE_FAST = 1'b1
    } rate_e;

    localparam int NUM_SETS = 2;
    localparam int MIN_SEG1 = 2;
    localparam int MIN_SEG2 = 1;
endpackage

// File: rtl/timing_set_latch.sv
// Holds one timing set, captured on a frame-start pulse.
// Outputs the stored values clamped to their legal minimums.
// Assumes: SEG1_W >= 2. Reset leaves all fields zero, which clamps to the minimum bit.
module timing_set_latch #(
    parameter int PRESC_W = 6,
    parameter int SEG1_W  = 6,
    parameter int SEG2_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [PRESC_W-1:0] presc_in,
    input  logic [SEG1_W-1:0]  seg1_in,
    input  logic [SEG2_W-1:0]  seg2_in,
    output logic [PRESC_W-1:0] presc_eff,
    output logic [SEG1_W-1:0]  seg1_eff,
    output logic [SEG2_W-1:0]  seg2_eff
);
    import dual_rate_pkg::*;

    logic [PRESC_W-1:0] presc_q;
    logic [SEG1_W-1:0]  seg1_q;
    logic [SEG2_W-1:0]  seg2_q;

    // Capture the raw configuration at the start of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= '0;
            seg1_q  <= '0;
            seg2_q  <= '0;
        end else if (load) begin
            presc_q <= presc_in;
            seg1_q  <= seg1_in;
            seg2_q  <= seg2_in;
        end
    end

    // Raise each field to its minimum so that a bit is never shorter than four quanta.
    always_comb begin
        presc_eff = (presc_q == '0) ? PRESC_W'(1) : presc_q;
        seg1_eff  = (seg1_q < SEG1_W'(MIN_SEG1)) ? SEG1_W'(MIN_SEG1) : seg1_q;
        seg2_eff  = (seg2_q < SEG2_W'(MIN_SEG2)) ? SEG2_W'(MIN_SEG2) : seg2_q;
    end

    p_clamped_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (presc_eff != '0) && (seg1_eff >= SEG1_W'(MIN_SEG1)) && (seg2_eff != '0));
endmodule

// File: rtl/tq_divider.sv
// Divides the clock into time quanta of presc clocks each.
// Assumes: presc >= 1 and stable within a bit. A restart begins a new quantum.
module tq_divider #(
    parameter int PRESC_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [PRESC_W-1:0] presc,
    output logic               tq_strobe
);
    logic [PRESC_W-1:0] clk_cnt;

    assign tq_strobe = (clk_cnt == presc - PRESC_W'(1));

    // Count clocks within the quantum and wrap on its last clock.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            clk_cnt <= '0;
        end else if (tq_strobe) begin
            clk_cnt <= '0;
        end else begin
            clk_cnt <= clk_cnt + PRESC_W'(1);
        end
    end

    p_count_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clk_cnt < presc);
endmodule

// File: rtl/bit_sequencer.sv
// Counts quanta within a bit and produces the sample-point and bit-end strobes.
// Assumes: seg1 >= 2, seg2 >= 1, and both stable within a bit.
module bit_sequencer #(
    parameter int SEG1_W = 6,
    parameter int SEG2_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              tq_in,
    input  logic [SEG1_W-1:0] seg1,
    input  logic [SEG2_W-1:0] seg2,
    output logic              sample_pt,
    output logic              bit_end
);
    localparam int WIDE_W = (SEG1_W > SEG2_W) ? SEG1_W : SEG2_W;
    localparam int BIT_W  = WIDE_W + 1;

    logic [BIT_W-1:0] tq_idx;
    logic [BIT_W-1:0] last_idx;
    logic [BIT_W-1:0] sample_idx;

    // The index of the last quantum is seg1 + seg2, because the sync quantum is index 0.
    always_comb begin
        sample_idx = BIT_W'(seg1);
        last_idx   = BIT_W'(seg1) + BIT_W'(seg2);
        sample_pt  = tq_in && (tq_idx == sample_idx);
        bit_end    = tq_in && (tq_idx == last_idx);
    end

    // Advance the quantum index and wrap at the end of the bit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            tq_idx <= '0;
        end else if (bit_end) begin
            tq_idx <= '0;
        end else if (tq_in) begin
            tq_idx <= tq_idx + BIT_W'(1);
        end
    end

    p_restart_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (tq_idx == '0));
    p_idx_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tq_idx <= last_idx);
endmodule

// File: rtl/rate_phase_ctrl.sv
// Chooses the timing set for the next bit from the protocol-layer requests.
// Requests are collected during a bit and applied on its bit_end.
// A return-to-slow request wins over a switch-to-fast request.
// Assumes: requests are single-cycle pulses and may coincide with bit_end.
module rate_phase_ctrl (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                bit_end,
    input  logic                brs_recessive,
    input  logic                crc_delim,
    input  logic                err_det,
    output dual_rate_pkg::rate_e rate
);
    import dual_rate_pkg::*;

    logic pend_fast;
    logic pend_slow;
    logic want_fast;
    logic want_slow;

    // Merge the stored requests with this clock's pulses.
    always_comb begin
        want_fast = pend_fast || (brs_recessive && (rate == RATE_SLOW));
        want_slow = pend_slow || crc_delim || err_det;
    end

    // Apply the merged request only at a bit boundary; frame start forces the slow set.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start) begin
            rate      <= RATE_SLOW;
            pend_fast <= 1'b0;
            pend_slow <= 1'b0;
        end else if (bit_end) begin
            if (want_slow) begin
                rate <= RATE_SLOW;
            end else if (want_fast) begin
                rate <= RATE_FAST;
            end
            pend_fast <= 1'b0;
            pend_slow <= 1'b0;
        end else begin
            pend_fast <= want_fast;
            pend_slow <= want_slow;
        end
    end

    p_error_forces_slow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_end && err_det && !frame_start) |=> (rate == RATE_SLOW));
    p_crc_forces_slow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_end && crc_delim && !frame_start) |=> (rate == RATE_SLOW));
    p_fast_needs_brs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rate == RATE_FAST) && ($past(rate) == RATE_SLOW) |-> $past(want_fast));
endmodule

// File: rtl/dual_rate_bit_timer.sv
// Top level: a bit timer with two timing sets, selected by the rate-switch and return requests.
// Structure: two timing-set latches, one quantum divider, one bit sequencer, and one phase controller.
// Assumes: SEG2_W <= SEG1_W + 1 and SEG1_W >= 2.
module dual_rate_bit_timer #(
    parameter int PRESC_W = 6,
    parameter int SEG1_W  = 6,
    parameter int SEG2_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic [PRESC_W-1:0] slow_presc,
    input  logic [SEG1_W-1:0]  slow_seg1,
    input  logic [SEG2_W-1:0]  slow_seg2,
    input  logic [PRESC_W-1:0] fast_presc,
    input  logic [SEG1_W-1:0]  fast_seg1,
    input  logic [SEG2_W-1:0]  fast_seg2,
    input  logic               brs_recessive,
    input  logic               crc_delim,
    input  logic               err_det,
    output logic               tq_strobe,
    output logic               sample_pt,
    output logic               bit_end,
    output logic               fast_phase
);
    import dual_rate_pkg::*;

    logic [NUM_SETS-1:0][PRESC_W-1:0] presc_raw, presc_set;
    logic [NUM_SETS-1:0][SEG1_W-1:0]  seg1_raw, seg1_set;
    logic [NUM_SETS-1:0][SEG2_W-1:0]  seg2_raw, seg2_set;
    rate_e                            rate;
    logic [PRESC_W-1:0]               presc_act;
    logic [SEG1_W-1:0]                seg1_act;
    logic [SEG2_W-1:0]                seg2_act;

    // Route the configuration ports into per-set arrays.
    always_comb begin
        presc_raw[RATE_SLOW] = slow_presc;
        seg1_raw[RATE_SLOW]  = slow_seg1;
        seg2_raw[RATE_SLOW]  = slow_seg2;
        presc_raw[RATE_FAST] = fast_presc;
        seg1_raw[RATE_FAST]  = fast_seg1;
        seg2_raw[RATE_FAST]  = fast_seg2;
    end

    generate
        for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
            timing_set_latch #(
                .PRESC_W(PRESC_W),
                .SEG1_W (SEG1_W),
                .SEG2_W (SEG2_W)
            ) i_set (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (frame_start),
                .presc_in (presc_raw[g]),
                .seg1_in  (seg1_raw[g]),
                .seg2_in  (seg2_raw[g]),
                .presc_eff(presc_set[g]),
                .seg1_eff (seg1_set[g]),
                .seg2_eff (seg2_set[g])
            );
        end
    endgenerate

    // Select the active set for the current bit.
    always_comb begin
        presc_act  = presc_set[rate];
        seg1_act   = seg1_set[rate];
        seg2_act   = seg2_set[rate];
        fast_phase = (rate == RATE_FAST);
    end

    tq_divider #(.PRESC_W(PRESC_W)) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (frame_start),
        .presc    (presc_act),
        .tq_strobe(tq_strobe)
    );

    bit_sequencer #(.SEG1_W(SEG1_W), .SEG2_W(SEG2_W)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (frame_start),
        .tq_in    (tq_strobe),
        .seg1     (seg1_act),
        .seg2     (seg2_act),
        .sample_pt(sample_pt),
        .bit_end  (bit_end)
    );

    rate_phase_ctrl i_phase (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .bit_end      (bit_end),
        .brs_recessive(brs_recessive),
        .crc_delim    (crc_delim),
        .err_det      (err_det),
        .rate         (rate)
    );

    p_sample_on_quantum_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_pt |-> tq_strobe);
    p_end_on_quantum_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |-> tq_strobe);
    p_sample_not_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_pt && bit_end));
    p_switch_at_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fast_phase) |-> $past(bit_end || frame_start));
    p_start_selects_slow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !fast_phase);
endmodule

// File: tb/test_dual_rate_bit_timer.sv
module test_dual_rate_bit_timer;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 6;
    localparam int S1W = 6;
    localparam int S2W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic [PW-1:0] slow_presc = '0, fast_presc = '0;
    logic [S1W-1:0] slow_seg1 = '0, fast_seg1 = '0;
    logic [S2W-1:0] slow_seg2 = '0, fast_seg2 = '0;
    logic brs_recessive = 1'b0, crc_delim = 1'b0, err_det = 1'b0;
    logic tq_strobe, sample_pt, bit_end, fast_phase;

    int n_tests = 0;
    int n_fail = 0;

    dual_rate_bit_timer #(.PRESC_W(PW), .SEG1_W(S1W), .SEG2_W(S2W)) i_dual_rate_bit_timer (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .slow_presc(slow_presc), .slow_seg1(slow_seg1), .slow_seg2(slow_seg2),
        .fast_presc(fast_presc), .fast_seg1(fast_seg1), .fast_seg2(fast_seg2),
        .brs_recessive(brs_recessive), .crc_delim(crc_delim), .err_det(err_det),
        .tq_strobe(tq_strobe), .sample_pt(sample_pt), .bit_end(bit_end), .fast_phase(fast_phase)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got hung exp done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Checks one whole bit, clock by clock. The call must start at the negedge of clock 0 of the bit.
    // p, s1, s2 are the effective set values; inj is {err, crc, brs}, driven in clock inj_at.
    task automatic run_bit(input string tag, input int p, input int s1, input int s2,
                           input logic exp_fast, input int inj_at, input logic [2:0] inj);
        int len = p * (1 + s1 + s2);
        int bad_at = -1;
        logic [3:0] got_v = '0, exp_v = '0;
        for (int i = 0; i < len; i++) begin
            logic [3:0] e;
            logic [3:0] g;
            e = {((i + 1) % p == 0), (i == p * (1 + s1) - 1), (i == len - 1), exp_fast};
            g = {tq_strobe, sample_pt, bit_end, fast_phase};
            if (g !== e && bad_at < 0) begin
                bad_at = i;
                got_v = g;
                exp_v = e;
            end
            {err_det, crc_delim, brs_recessive} = (i == inj_at) ? inj : 3'b000;
            @(negedge clk);
        end
        {err_det, crc_delim, brs_recessive} = 3'b000;
        n_tests++;
        if (bad_at >= 0) begin
            n_fail++;
            $display("FAIL %s clock %0d {tq,sample,end,fast}: got %b exp %b", tag, bad_at, got_v, exp_v);
        end
    endtask

    task automatic start_frame(input int np, input int ns1, input int ns2,
                               input int fp, input int fs1, input int fs2);
        slow_presc = PW'(np); slow_seg1 = S1W'(ns1); slow_seg2 = S2W'(ns2);
        fast_presc = PW'(fp); fast_seg1 = S1W'(fs1); fast_seg2 = S2W'(fs2);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        n_tests++;
        if (fast_phase !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 fast_phase in reset: got %b exp 0", fast_phase);
        end
        rst_n = 1'b1;
        // R1: with the reset configuration, a quantum is one clock and a bit is four clocks.
        run_bit("R1", 1, 2, 1, 1'b0, -1, 3'b000);
        run_bit("R1", 1, 2, 1, 1'b0, -1, 3'b000);

        // R4: a prescaler of 0 acts as 1, S1 of 1 acts as 2, and S2 of 0 acts as 1.
        start_frame(0, 1, 0, 0, 0, 0);
        run_bit("R4 clamp", 1, 2, 1, 1'b0, -1, 3'b000);

        // R6: without a rate-switch pulse, every bit of the frame stays on the slow set.
        start_frame(2, 3, 2, 1, 2, 1);
        for (int b = 0; b < 4; b++) run_bit("R6 dominant", 2, 3, 2, 1'b0, -1, 3'b000);

        // R5: configuration changes after capture are ignored.
        slow_presc = 5; slow_seg1 = 9; slow_seg2 = 7;
        run_bit("R5 latched", 2, 3, 2, 1'b0, 4, 3'b001);
        fast_presc = 4; fast_seg1 = 8;
        run_bit("R5 latched fast", 1, 2, 1, 1'b1, -1, 3'b000);

        // R9: a rate-switch pulse during a fast bit is ignored.
        run_bit("R9 brs in fast", 1, 2, 1, 1'b1, 1, 3'b001);
        run_bit("R9 still fast", 1, 2, 1, 1'b1, 3, 3'b100);
        // R8: the error in the last clock of the previous bit returns to the slow set.
        run_bit("R8 err at end", 2, 3, 2, 1'b0, -1, 3'b000);

        // R6: a rate-switch pulse in the clock of bit_end still applies to the next bit.
        start_frame(1, 2, 1, 2, 2, 2);
        run_bit("R6 brs at end", 1, 2, 1, 1'b0, 3, 3'b001);
        run_bit("R6 fast", 2, 2, 2, 1'b1, 5, 3'b100);
        // R8: the error in the middle of the fast bit gives a slow bit next.
        run_bit("R8 err mid", 1, 2, 1, 1'b0, 1, 3'b101);
        // R8: an error in the same bit as the rate-switch pulse cancels the switch.
        run_bit("R8 cancel", 1, 2, 1, 1'b0, -1, 3'b000);
        run_bit("R8 slow kept", 1, 2, 1, 1'b0, 0, 3'b001);
        run_bit("R6 fast again", 2, 2, 2, 1'b1, 3, 3'b000);

        // R5: a restart in the middle of a fast bit gives a new slow bit at quantum 0.
        start_frame(3, 2, 1, 1, 3, 3);
        n_tests++;
        if (fast_phase !== 1'b0) begin
            n_fail++;
            $display("FAIL R5 restart: got fast=%b exp 0", fast_phase);
        end
        run_bit("R5 restart", 3, 2, 1, 1'b0, -1, 3'b000);

        // R2 R3 R6 R7: sweep over both sets, running a full slow, fast, slow sequence each time.
        for (int p = 1; p <= 3; p++) begin
            for (int a = 0; a < 3; a++) begin
                for (int c = 0; c < 3; c++) begin
                    int s1 = (a == 0) ? 2 : (a == 1) ? 3 : 5;
                    int s2 = c + 1;
                    int fp = 1 + (p % 2);
                    int fs1 = 2 + (a % 2);
                    int fs2 = 1 + (c % 2);
                    int flen = fp * (1 + fs1 + fs2);
                    start_frame(p, s1, s2, fp, fs1, fs2);
                    run_bit("R2 R3 slow", p, s1, s2, 1'b0, -1, 3'b000);
                    run_bit("R6 brs mid", p, s1, s2, 1'b0, p * s1, 3'b001);
                    run_bit("R3 fast", fp, fs1, fs2, 1'b1, -1, 3'b000);
                    run_bit("R7 crc", fp, fs1, fs2, 1'b1, (p + a + c) % flen, 3'b010);
                    run_bit("R7 back slow", p, s1, s2, 1'b0, -1, 3'b000);
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule